// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block reduces a set of pending interrupt levels into one hard-interrupt request and one trap type for a processor core. Pending levels come from two places. One is a 16-bit external pending mask. The other is a software interrupt register, whose two timer-match bits are not passed through directly: either of them being set asserts level 14 instead. The arbiter compares the merged mask against the core's current processor interrupt level. It picks the highest pending level that is above that threshold. It then decides whether to raise a new request, keep the current one, or withdraw it.

The core gives the arbiter its global interrupt enable, its current trap level and the trap type it is servicing. While a higher external-interrupt trap is in service, the arbiter does not nest a lower one. A busy flag from the vector-interrupt unit freezes the arbiter completely, because vector interrupts outrank every level interrupt. The outputs are registered. Each input change shows up one clock later.

Top module: `irq_level_arbiter`

## Requirements
- R1: During and directly after a synchronous active-low reset, `irq_req` is 0 and `irq_tt` is 0.
- R2: The merged pending mask is `ext_pend` ORed with `soft_int[15:1]`, placed at levels 15..1. Bit 0 (tick match) and bit 16 (system tick match) of `soft_int` never assert their own level position.
- R3: If `soft_int[0]` or `soft_int[16]` is 1, level 14 counts as pending.
- R4: While `vec_busy` is 1, `irq_req` and `irq_tt` keep their values, whatever the other inputs are.
- R5: If the merged mask has no bit at a position above `pil`, an asserted request is withdrawn: `irq_req` goes to 0 and `irq_tt` goes to 0. With no request asserted, the outputs stay as they are.
- R6: With `ints_en` at 1, the highest set level L with L > `pil` is chosen. The candidate trap type is 0x40 | L, so levels 1..15 give 0x41..0x4F. Level 0 is never requested.
- R7: The candidate is not raised, and the outputs hold, when all of these are true: `trap_lvl` is nonzero, `act_tt[8:4]` equals 5'h04 (an external-interrupt trap), and `act_tt` is greater than the candidate.
- R8: The request is set to 1 and `irq_tt` is loaded with the candidate only when the candidate differs from the current `irq_tt`. Otherwise the outputs hold.
- R9: With `ints_en` at 0, an asserted request is withdrawn (`irq_req`=0, `irq_tt`=0). An idle arbiter stays idle.
- R10: The outputs reflect the inputs present at a rising clock edge right after that edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pend | input | 16 | External pending level mask, bit i = level i |
| soft_int | input | 17 | Software interrupt register; bit 0 tick match, bit 16 system tick match, bits 15:1 levels |
| pil | input | 4 | Current processor interrupt level |
| ints_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| act_tt | input | 9 | Trap type currently being serviced |
| vec_busy | input | 1 | Vector-interrupt unit holds a pending vector interrupt |
| irq_req | output | 1 | Hard-interrupt request to the core |
| irq_tt | output | 9 | Selected trap type, 0 when no request |

## Verification
The bench targets five corner cases:
- **Level at the threshold.** A level equal to `pil` must not be raised. A design that compared with `>=` would raise it.
- **Timer bits.** These are checked alone and together with real level-14 and level-0 bits. A design that passed bit 0 through as level 0, or ignored bit 16, would withdraw the request or select the wrong level.
- **Nesting guard.** This is driven with the active trap type just above, equal to, and just below the candidate, and with a non-external trap type. An off-by-one comparison or a missing class check would show up as a wrong raise or a wrong hold.
- **Vector-busy freeze.** This is applied while the other inputs would otherwise demand a withdrawal. A leaky freeze would drop the request.
- **Same-level re-evaluation.** This must leave the outputs unchanged.

// File: rtl/irqa_pkg.sv
// Shared constants and types for the interrupt level arbiter.
// Assumes a 9-bit trap type field whose external-interrupt class is 0x40..0x4F.
package irqa_pkg;
    parameter int NUM_LVL   = 16;
    parameter int LVL_W     = $clog2(NUM_LVL);
    parameter int SOFT_W    = 17;
    parameter int TT_W      = 9;
    parameter int TL_W      = 3;
    parameter int TICK_BIT  = 0;
    parameter int STICK_BIT = SOFT_W - 1;
    parameter int TIMER_LVL = 14;
    parameter logic [TT_W-1:0] EXT_BASE = 9'h040;
    localparam int CLASS_LSB = LVL_W;

    typedef logic [TT_W-1:0]    tt_t;
    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_LVL-1:0] mask_t;
endpackage

// File: rtl/irqa_pend_merge.sv
// Builds the merged pending mask from the external levels and the
// software interrupt register. Timer-match bits never assert their own
// position; either one asserts TIMER_LVL instead.
// Assumes TICK_BIT and STICK_BIT sit outside 1..NUM_LVL-1 or are deliberately masked.
module irqa_pend_merge
    import irqa_pkg::*;
#(
    parameter int LVLS  = NUM_LVL,
    parameter int SW    = SOFT_W,
    parameter int TBIT  = TICK_BIT,
    parameter int SBIT  = STICK_BIT,
    parameter int TLVL  = TIMER_LVL
) (
    input  logic [LVLS-1:0] ext_pend,
    input  logic [SW-1:0]   soft_int,
    output logic [LVLS-1:0] merged
);
    logic timer_hit;

    // Either timer match requests the timer level.
    always_comb timer_hit = soft_int[TBIT] | soft_int[SBIT];

    for (genvar i = 0; i < LVLS; i++) begin : g_lvl
        logic sw_bit;
        if (i == TBIT || i == SBIT || i >= SW) begin : g_masked
            // Timer or absent bit: no direct contribution.
            always_comb sw_bit = 1'b0;
        end else begin : g_pass
            // Ordinary software level bit passes straight through.
            always_comb sw_bit = soft_int[i];
        end
        if (i == TLVL) begin : g_timer
            // Timer level also takes the folded timer-match request.
            always_comb merged[i] = ext_pend[i] | sw_bit | timer_hit;
        end else begin : g_plain
            // Plain level: external or software.
            always_comb merged[i] = ext_pend[i] | sw_bit;
        end
    end
endmodule

// File: rtl/irqa_prio_pick.sv
// Priority encoder: finds the highest set mask bit strictly above the
// current interrupt level. found=0 means nothing exceeds the threshold.
// Assumes LVLS is a power of two matching the level field width.
module irqa_prio_pick
    import irqa_pkg::*;
#(
    parameter int LVLS = NUM_LVL,
    parameter int LW   = LVL_W
) (
    input  logic [LVLS-1:0] mask,
    input  logic [LW-1:0]   pil,
    output logic            found,
    output logic [LW-1:0]   lvl
);
    // Ascending scan; the last qualifying bit is the highest one.
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = 0; i < LVLS; i++) begin
            if (mask[i] && (i > int'(pil))) begin
                found = 1'b1;
                lvl   = LW'(i);
            end
        end
    end

    // R6: a reported winner is pending and above the threshold
    always_comb begin
        if (found) begin
            r6_winner_valid_chk: assert (mask[lvl] && (lvl > pil));
        end
    end
endmodule

// File: rtl/irqa_arb_ctrl.sv
// Decision and output register stage. Holds during vector busy, withdraws
// on no eligible level or disabled interrupts, suppresses nesting under
// a higher external trap, and raises only on a new trap type.
// Assumes the core reports act_tt only meaningfully when trap_lvl != 0.
module irqa_arb_ctrl
    import irqa_pkg::*;
#(
    parameter int LW  = LVL_W,
    parameter int TW  = TT_W,
    parameter int TLW = TL_W,
    parameter logic [TW-1:0] BASE = EXT_BASE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           found,
    input  logic [LW-1:0]  lvl,
    input  logic [LW-1:0]  pil,
    input  logic           ints_en,
    input  logic [TLW-1:0] trap_lvl,
    input  logic [TW-1:0]  act_tt,
    input  logic           vec_busy,
    output logic           irq_req,
    output logic [TW-1:0]  irq_tt
);
    localparam int CLS_W = TW - LW;

    logic [TW-1:0] cand_tt;
    logic          nest_block;
    logic          req_nxt;
    logic [TW-1:0] tt_nxt;

    // Candidate trap type from the winning level.
    always_comb cand_tt = BASE | TW'(lvl);

    // Nesting guard: a higher external trap is already in service.
    always_comb nest_block = (trap_lvl != '0)
                          && (act_tt[TW-1:LW] == BASE[TW-1:LW])
                          && (act_tt > cand_tt);

    // Next-state decision in priority order.
    always_comb begin
        req_nxt = irq_req;
        tt_nxt  = irq_tt;
        if (vec_busy) begin
            req_nxt = irq_req;
        end else if (!found || !ints_en) begin
            if (irq_req) begin
                req_nxt = 1'b0;
                tt_nxt  = '0;
            end
        end else if (!nest_block && (cand_tt != irq_tt)) begin
            req_nxt = 1'b1;
            tt_nxt  = cand_tt;
        end
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_tt  <= '0;
        end else begin
            irq_req <= req_nxt;
            irq_tt  <= tt_nxt;
        end
    end

    // R4
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

    // R9
    dis_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && !ints_en && irq_req) |=> (!irq_req && irq_tt == '0));

    // R6
    req_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_tt[TW-1:LW] == BASE[TW-1:LW] && irq_tt[LW-1:0] != '0));

    // R5
    raise_above_pil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_tt[LW-1:0] > $past(pil)));

    // R7
    no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !($past(trap_lvl) != '0
                             && $past(act_tt[TW-1:LW]) == CLS_W'(BASE[TW-1:LW])
                             && $past(act_tt) > irq_tt));
endmodule

// File: rtl/irq_level_arbiter.sv
// Top of the interrupt level arbiter: merges pending sources, picks the
// highest level above the current interrupt level, and registers the
// request and trap type for the core.
// Assumes all inputs are synchronous to clk.
module irq_level_arbiter
    import irqa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] ext_pend,
    input  logic [SOFT_W-1:0]  soft_int,
    input  logic [LVL_W-1:0]   pil,
    input  logic               ints_en,
    input  logic [TL_W-1:0]    trap_lvl,
    input  logic [TT_W-1:0]    act_tt,
    input  logic               vec_busy,
    output logic               irq_req,
    output logic [TT_W-1:0]    irq_tt
);
    mask_t merged;
    logic  found;
    lvl_t  lvl;

    irqa_pend_merge u_merge (
        .ext_pend (ext_pend),
        .soft_int (soft_int),
        .merged   (merged)
    );

    irqa_prio_pick u_pick (
        .mask  (merged),
        .pil   (pil),
        .found (found),
        .lvl   (lvl)
    );

    irqa_arb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .found    (found),
        .lvl      (lvl),
        .pil      (pil),
        .ints_en  (ints_en),
        .trap_lvl (trap_lvl),
        .act_tt   (act_tt),
        .vec_busy (vec_busy),
        .irq_req  (irq_req),
        .irq_tt   (irq_tt)
    );
endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ext_pend;
    logic [16:0] soft_int;
    logic [3:0]  pil;
    logic        ints_en;
    logic [2:0]  trap_lvl;
    logic [8:0]  act_tt;
    logic        vec_busy;
    logic        irq_req;
    logic [8:0]  irq_tt;

    int n_chk = 0;
    int n_bad = 0;
    logic       m_req;
    logic [8:0] m_tt;

    always #5 clk = ~clk;

    irq_level_arbiter u_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_pend(ext_pend), .soft_int(soft_int),
        .pil(pil), .ints_en(ints_en), .trap_lvl(trap_lvl), .act_tt(act_tt),
        .vec_busy(vec_busy), .irq_req(irq_req), .irq_tt(irq_tt)
    );

    // Merged mask per R2/R3.
    function automatic logic [15:0] merge_m(input logic [15:0] e, input logic [16:0] s);
        logic [15:0] m;
        m = e | {s[15:1], 1'b0};
        if (s[0] || s[16]) m[14] = 1'b1;
        return m;
    endfunction

    // Reference next state; returns the requirement that decided it.
    task automatic model_step(output string tag);
        logic [15:0] m;
        int best;
        logic [8:0] cand;
        m = merge_m(ext_pend, soft_int);
        best = -1;
        for (int i = 15; i > int'(pil); i--) if (m[i] && best < 0) best = i;
        if (vec_busy) tag = "R4";
        else if (best < 0) begin
            tag = "R5";
            if (m_req) begin m_req = 1'b0; m_tt = '0; end
        end else if (!ints_en) begin
            tag = "R9";
            if (m_req) begin m_req = 1'b0; m_tt = '0; end
        end else begin
            cand = 9'h040 | 9'(best);
            if (trap_lvl != 0 && act_tt[8:4] == 5'h04 && act_tt > cand) tag = "R7";
            else if (cand != m_tt) begin tag = "R6"; m_req = 1'b1; m_tt = cand; end
            else tag = "R8";
        end
    endtask

    task automatic cmp(input string tag);
        n_chk++;
        if (irq_req !== m_req || irq_tt !== m_tt) begin
            n_bad++;
            $display("FAIL %s: req=%0b tt=%h expected req=%0b tt=%h", tag, irq_req, irq_tt, m_req, m_tt);
        end
    endtask

    // Apply one vector at negedge, check one clock later (R10).
    task automatic apply(input logic [15:0] e, input logic [16:0] s, input logic [3:0] p,
                         input logic en, input logic [2:0] tl, input logic [8:0] at,
                         input logic vb, input string force_tag);
        string tag;
        ext_pend = e; soft_int = s; pil = p; ints_en = en;
        trap_lvl = tl; act_tt = at; vec_busy = vb;
        model_step(tag);
        @(posedge clk); @(negedge clk);
        cmp(force_tag == "" ? tag : {force_tag, "/", tag});
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; ext_pend = '0; soft_int = '0; pil = '0; ints_en = 1'b1;
        trap_lvl = '0; act_tt = '0; vec_busy = 1'b0;
        m_req = 1'b0; m_tt = '0;
        ext_pend = 16'h8000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cmp("R1");
        rst_n = 1'b1;
        // R10 / R6: single level, one clock later
        apply(16'h0020, '0, 4'd0, 1, 0, 0, 0, "R10");
        // R6: highest wins
        apply(16'h0424, '0, 4'd0, 1, 0, 0, 0, "R6");
        // R8: same candidate, hold
        apply(16'h0400, '0, 4'd2, 1, 0, 0, 0, "R8");
        // R5: level equal to pil not raised, withdraw
        apply(16'h0400, '0, 4'd10, 1, 0, 0, 0, "R5");
        // R5: idle stays idle
        apply(16'h0001, '0, 4'd0, 1, 0, 0, 0, "R5");
        // R3: tick bit -> level 14
        apply('0, 17'h00001, 4'd3, 1, 0, 0, 0, "R3");
        apply('0, '0, 4'd3, 1, 0, 0, 0, "R5");
        // R3: system tick bit -> level 14
        apply('0, 17'h10000, 4'd13, 1, 0, 0, 0, "R3");
        // R2: soft bits pass, level 15 from software
        apply('0, 17'h08000, 4'd0, 1, 0, 0, 0, "R2");
        // R2: tick bit alone at pil 14 gives nothing above
        apply('0, 17'h00001, 4'd14, 1, 0, 0, 0, "R2");
        // R4: vec busy freezes over a raise demand
        apply(16'h0200, '0, 4'd0, 1, 0, 0, 1, "R4");
        apply(16'h0200, '0, 4'd0, 1, 0, 0, 0, "R6");
        // R4: freeze over withdraw demand
        apply('0, '0, 4'd0, 0, 0, 0, 1, "R4");
        // R9: disabled withdraws
        apply(16'h0200, '0, 4'd0, 0, 0, 0, 0, "R9");
        // R7: nesting guard around the candidate 0x45
        apply(16'h0020, '0, 4'd0, 1, 3'd1, 9'h046, 0, "R7");
        apply(16'h0020, '0, 4'd0, 1, 3'd1, 9'h045, 0, "R7");
        apply('0, '0, 4'd0, 1, 0, 0, 0, "R5");
        apply(16'h0020, '0, 4'd0, 1, 3'd1, 9'h060, 0, "R7");
        apply('0, '0, 4'd0, 1, 0, 0, 0, "R5");
        apply(16'h0020, '0, 4'd0, 1, 3'd0, 9'h04F, 0, "R7");
        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] e; logic [16:0] s; logic [8:0] at;
            e  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            s  = 17'($urandom) & 17'($urandom) & 17'($urandom) & 17'($urandom);
            at = ($urandom % 4 != 0) ? (9'h040 | 9'($urandom % 16)) : 9'($urandom);
            apply(e, s, 4'($urandom), ($urandom % 6) != 0, 3'($urandom % 2 ? 0 : $urandom),
                  at, ($urandom % 8) == 0, "");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule